// File: doc/BRIEF.md
# Keypad matrix scanner and encoder

This block reads a grid of plain on/off switches that has four columns and either four or five rows. It drives one column low at a time, walking across the columns on each scan tick from an internal divider. The rows are pulled up outside the block, so a row reads low only when a closed switch joins it to the column that is driven at that moment. The block passes each row line through a synchronizer. When the active column pulls a row low, the block stops the walk on that column and locks out every other row. It then reports the switch as a binary key code and raises a key-detected flag.

The flag and code are raw. A debounce stage downstream watches the flag, decides whether a closure is valid, and can pulse the restart input to drop the capture and scan again. The block also resumes scanning by itself when the captured row goes high again, whether from a bounce or from a release. A parameter selects four or five rows, and the code width follows that choice.

Top module: `kps_scanner`

## Requirements
- R1: After reset, column 0 is the only column driven low (col_n = 4'b1110), key_hit is 0 and key_code is 0.
- R2: Exactly one of the four col_n bits is low in every cycle.
- R3: With no row low, the low column moves to the next higher index on each scan tick (one tick every TICK_DIV clock cycles), in the order 0, 1, 2, 3, 0. It does not move between ticks.
- R4: A switch at row r and column c is detected only while column c is driven. Detection raises key_hit, and col_n then stays on column c for as long as key_hit is 1.
- R5: While key_hit is 1, key_code = 4*r + c, with rows and columns counted from 0. The column sits in bits [1:0] and the row in the bits above them, so row 4 sets bit 4 and leaves bits [3:2] at 0. While key_hit is 0, key_code is 0.
- R6: When several rows read low on the frozen column, the lowest row index is captured. While key_hit is 1, rows other than the captured one are ignored, so the code does not change when a second switch closes.
- R7: When the captured row reads high again, key_hit falls within SYNC_STAGES+2 cycles. Scanning then resumes, and the next column follows at the next scan tick.
- R8: A one-cycle pulse on restart while key_hit is 1 makes key_hit 0 in the next cycle. If the switch is still closed, it is then captured again with the same code.
- R9: With ROWS = 4, key_code is 4 bits wide and only 16 codes exist. A closure on a fifth row line is not wired and is never reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| row_n | input | ROWS | Row lines, active low, asynchronous to clk |
| restart | input | 1 | Debounce request to drop the capture and rescan |
| col_n | output | 4 | Column strobes, one low at a time |
| key_code | output | CODE_W | Captured key code, 0 when idle |
| key_hit | output | 1 | A row is captured on the frozen column |

## Verification
On every cycle, assertions check the following:
- only one column is strobed;
- the column index moves only by one step;
- the column is held while a row is captured;
- the captured row index does not change during a capture;
- a release or a restart ends the capture one cycle later;
- the code is zero when idle and stable while a key is held.

The following can only be shown by the bench's scenarios:
- each of the twenty switch positions maps to the expected code;
- the scan order and the tick interval are correct;
- lockout of a second switch works, with hand-over to it after the first is released;
- a held switch is captured again after a restart;
- the fifth row line is absent in the four-row variant.

// File: rtl/kps_pkg.sv
package kps_pkg;
  localparam int unsigned KPS_COLS  = 4;
  localparam int unsigned KPS_COL_W = 2;

  function automatic int unsigned kps_row_w(input int unsigned rows);
    return (rows > 4) ? 3 : 2;
  endfunction
endpackage

// File: rtl/kps_tick_div.sv
module kps_tick_div #(
  parameter int unsigned DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/kps_row_sync.sv
module kps_row_sync #(
  parameter int unsigned ROWS   = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ROWS-1:0] row_n,
  output logic [ROWS-1:0] row_act
);
  logic [ROWS-1:0] stg_q [STAGES];

  genvar k;
  generate
    for (k = 0; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[k] <= '1;
        else if (k == 0) stg_q[k] <= row_n;
        else stg_q[k] <= stg_q[(k == 0) ? 0 : k-1];
      end
    end
  endgenerate

  assign row_act = ~stg_q[STAGES-1];
endmodule

// File: rtl/kps_col_drive.sv
module kps_col_drive
  import kps_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [KPS_COL_W-1:0] col_sel,
  output logic [KPS_COLS-1:0]  col_n
);
  genvar i;
  generate
    for (i = 0; i < KPS_COLS; i++) begin : g_col
      assign col_n[i] = (col_sel != KPS_COL_W'(i));
    end
  endgenerate

  p_one_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(col_n) == 3)
    else $error("R2: column strobe not one-hot low");
endmodule

// File: rtl/kps_scan_core.sv
module kps_scan_core
  import kps_pkg::*;
#(
  parameter int unsigned ROWS        = 5,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RW          = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 restart,
  input  logic [ROWS-1:0]      row_act,
  output logic [KPS_COL_W-1:0] col_sel,
  output logic                 locked,
  output logic [RW-1:0]        lrow
);
  localparam int unsigned BW = $clog2(SYNC_STAGES + 1);
  localparam logic [BW-1:0] BLANK = BW'(SYNC_STAGES);

  logic [KPS_COL_W-1:0] cnt_q, cnt_d;
  logic                 lk_q, lk_d;
  logic [RW-1:0]        lr_q, lr_d;
  logic [BW-1:0]        bl_q, bl_d;
  logic                 hit_any;
  logic [RW-1:0]        hit_idx;
  logic                 cur_row;

  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int r = ROWS - 1; r >= 0; r--) begin
      if (row_act[r]) begin
        hit_any = 1'b1;
        hit_idx = RW'(r);
      end
    end
  end

  always_comb begin
    cur_row = 1'b0;
    for (int r = 0; r < ROWS; r++) begin
      if (lr_q == RW'(r)) cur_row = row_act[r];
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    lk_d  = lk_q;
    lr_d  = lr_q;
    bl_d  = (bl_q != '0) ? bl_q - 1'b1 : bl_q;
    if (lk_q) begin
      if (restart || !cur_row) begin
        lk_d = 1'b0;
        bl_d = BLANK;
      end
    end else if ((bl_q == '0) && hit_any) begin
      lk_d = 1'b1;
      lr_d = hit_idx;
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
      bl_d  = BLANK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lk_q  <= 1'b0;
      lr_q  <= '0;
      bl_q  <= BLANK;
    end else begin
      cnt_q <= cnt_d;
      lk_q  <= lk_d;
      lr_q  <= lr_d;
      bl_q  <= bl_d;
    end
  end

  assign col_sel = cnt_q;
  assign locked  = lk_q;
  assign lrow    = lr_q;

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 2'd1))
    else $error("R3: column skipped");

  p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_q |=> (cnt_q == $past(cnt_q)))
    else $error("R4: column moved while captured");

  p_lockout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_q && $past(lk_q)) |-> $stable(lr_q))
    else $error("R6: captured row changed");

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_q && !cur_row) |=> !lk_q)
    else $error("R7: capture held after release");

  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_q && restart) |=> !lk_q)
    else $error("R8: restart ignored");
endmodule

// File: rtl/kps_scanner.sv
module kps_scanner
  import kps_pkg::*;
#(
  parameter int unsigned ROWS        = 5,
  parameter int unsigned TICK_DIV    = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned RW         = kps_row_w(ROWS),
  localparam int unsigned CODE_W     = RW + KPS_COL_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ROWS-1:0]     row_n,
  input  logic                restart,
  output logic [KPS_COLS-1:0] col_n,
  output logic [CODE_W-1:0]   key_code,
  output logic                key_hit
);
  logic                 tick;
  logic [ROWS-1:0]      row_act;
  logic [KPS_COL_W-1:0] col_sel;
  logic                 locked;
  logic [RW-1:0]        lrow;

  kps_tick_div #(.DIV(TICK_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  kps_row_sync #(.ROWS(ROWS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .row_n(row_n), .row_act(row_act)
  );

  kps_scan_core #(.ROWS(ROWS), .SYNC_STAGES(SYNC_STAGES), .RW(RW)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart),
    .row_act(row_act), .col_sel(col_sel), .locked(locked), .lrow(lrow)
  );

  kps_col_drive u_cols (
    .clk(clk), .rst_n(rst_n), .col_sel(col_sel), .col_n(col_n)
  );

  assign key_hit  = locked;
  assign key_code = locked ? {lrow, col_sel} : '0;

  p_idle_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !key_hit |-> (key_code == '0))
    else $error("R5: nonzero code while idle");

  p_held_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (key_hit && $past(key_hit)) |-> $stable(key_code))
    else $error("R6: code changed during capture");
endmodule

// File: tb/tb_kps_scanner.sv
module tb_kps_scanner;
  localparam int DIV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restart = 1'b0;
  logic [4:0] row_n;
  logic [3:0] row4_n;
  logic [3:0] col_n, col4_n;
  logic [4:0] key_code;
  logic [3:0] key4_code;
  logic key_hit, key4_hit;

  logic a_on = 0, b_on = 0;
  int ra = 0, ca = 0, rb = 0, cb = 0;
  int total = 0, bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int r = 0; r < 5; r++) begin
      row_n[r] = !((a_on && ra == r && !col_n[ca]) || (b_on && rb == r && !col_n[cb]));
    end
    for (int r = 0; r < 4; r++) begin
      row4_n[r] = !((a_on && ra == r && !col4_n[ca]) || (b_on && rb == r && !col4_n[cb]));
    end
  end

  kps_scanner #(.ROWS(5), .TICK_DIV(DIV), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .row_n(row_n), .restart(restart),
    .col_n(col_n), .key_code(key_code), .key_hit(key_hit));

  kps_scanner #(.ROWS(4), .TICK_DIV(DIV), .SYNC_STAGES(2)) dut4 (
    .clk(clk), .rst_n(rst_n), .row_n(row4_n), .restart(restart),
    .col_n(col4_n), .key_code(key4_code), .key_hit(key4_hit));

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      report();
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_hit(input int lim, input bit both);
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (key_hit && (!both || key4_hit)) break;
    end
  endtask

  task automatic wait_drop(input int lim);
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (!key_hit) break;
    end
  endtask

  function automatic int col_idx(input logic [3:0] c);
    for (int i = 0; i < 4; i++) if (!c[i]) return i;
    return -1;
  endfunction

  initial begin
    int prev, gap, stable_ok, code0, nc, lim;
    repeat (3) @(negedge clk);
    chk(col_n == 4'b1110, "R1 col after reset", col_n, 14);
    chk(key_hit == 0, "R1 key_hit after reset", key_hit, 0);
    chk(key_code == 0, "R1 code after reset", key_code, 0);
    rst_n = 1'b1;

    // R3: scan order and interval, no keys
    prev = col_idx(col_n);
    gap = 0;
    for (int n = 0; n < 6; n++) begin
      int k;
      for (k = 1; k < 4 * DIV; k++) begin
        @(negedge clk);
        chk(col_idx(col_n) >= 0, "R2 one column low", col_n, 0);
        if (col_idx(col_n) != prev) break;
      end
      chk(col_idx(col_n) == (prev + 1) % 4, "R3 next column", col_idx(col_n), (prev + 1) % 4);
      if (n > 0) chk(k == DIV, "R3 tick interval", k, DIV);
      prev = col_idx(col_n);
    end

    // R4 R5 R9: sweep all positions
    for (int r = 0; r < 5; r++) begin
      for (int c = 0; c < 4; c++) begin
        ra = r; ca = c; a_on = 1;
        wait_hit(12 * DIV, r < 4);
        chk(key_hit == 1, "R4 key detected", key_hit, 1);
        chk(key_code == 4 * r + c, "R5 key code", key_code, 4 * r + c);
        chk(col_idx(col_n) == c, "R4 column frozen", col_idx(col_n), c);
        if (r < 4) begin
          chk(key4_hit == 1 && key4_code == 4 * r + c, "R9 four-row code", key4_code, 4 * r + c);
        end
        stable_ok = 1;
        for (int i = 0; i < 3 * DIV; i++) begin
          @(negedge clk);
          if (!key_hit || col_idx(col_n) != c || key_code != 4 * r + c) stable_ok = 0;
        end
        chk(stable_ok == 1, "R4 held while row low", stable_ok, 1);
        if (r == 4) chk(key4_hit == 0, "R9 fifth row absent", key4_hit, 0);
        a_on = 0;
        wait_drop(6);
        chk(key_hit == 0, "R7 release drops key_hit", key_hit, 1'b0);
        lim = 0;
        for (int i = 0; i < DIV + 4; i++) begin
          @(negedge clk);
          if (col_idx(col_n) != c) break;
        end
        chk(col_idx(col_n) == (c + 1) % 4, "R7 scan resumes", col_idx(col_n), (c + 1) % 4);
        repeat (DIV) @(negedge clk);
      end
    end

    // R6: lockout and hand-over
    ra = 0; ca = 1; a_on = 1;
    wait_hit(12 * DIV, 0);
    code0 = key_code;
    chk(code0 == 1, "R6 first key", code0, 1);
    rb = 2; cb = 1; b_on = 1;
    repeat (3 * DIV) @(negedge clk);
    chk(key_hit == 1 && key_code == 1, "R6 second key locked out", key_code, 1);
    a_on = 0;
    wait_drop(6);
    chk(key_hit == 0, "R7 first released", key_hit, 0);
    wait_hit(12 * DIV, 0);
    chk(key_code == 9, "R6 hand-over to second key", key_code, 9);
    b_on = 0;
    wait_drop(6);
    repeat (2 * DIV) @(negedge clk);

    // R6: simultaneous rows, lowest wins
    ra = 3; ca = 2; rb = 1; cb = 2; a_on = 1; b_on = 1;
    wait_hit(12 * DIV, 0);
    chk(key_code == 6, "R6 lowest row priority", key_code, 6);
    a_on = 0; b_on = 0;
    wait_drop(6);
    repeat (2 * DIV) @(negedge clk);

    // R8: restart
    ra = 1; ca = 2; a_on = 1;
    wait_hit(12 * DIV, 0);
    chk(key_code == 6, "R8 held key", key_code, 6);
    restart = 1;
    @(negedge clk);
    restart = 0;
    chk(key_hit == 0, "R8 restart clears capture", key_hit, 0);
    wait_hit(12 * DIV, 0);
    chk(key_hit == 1 && key_code == 6, "R8 recapture same key", key_code, 6);
    a_on = 0;
    wait_drop(6);
    chk(key_hit == 0 && key_code == 0, "R5 idle code zero", key_code, 0);

    nc = 0;
    report();
  end
endmodule